// File: doc/BRIEF.md
# Deblocking Boundary Strength Engine

This block produces the 2-bit deblocking strength for 4-sample edge segments of a prediction unit. A caller starts a walk by giving the unit's origin (in 4-sample units), its size and whether the coding unit is split into two prediction units. The engine then requests one segment per cycle. For each request it presents the segment position and an edge mask. In the same cycle the caller returns the coding data of the two blocks P and Q that border that segment. One cycle later the engine emits the strength, tagged with the same position and mask, ready to be written into a strength map.

The walk covers the unit's left edge from top to bottom, then its top edge from the second column onward. The top-left segment serves both edges and is visited only once. When the unit is split, an internal horizontal edge follows. The strength rule gives 2 when an intra block borders a flagged edge. It gives 1 for coefficient activity on a transform edge, or for a motion mismatch on a prediction edge. In every other case it gives 0.

Top module: `dbk_bs_engine`

## Requirements
- R1: After reset, `busy`, `req_valid` and `res_valid` are all 0.
- R2: Let K = 2^(size_log2−2). A walk first requests column 0, rows 0 to K−1. Row 0 has mask 3 (both edges) and every other row has mask 1 (vertical edge). It then requests row 0, columns 1 to K−1, with mask 2 (horizontal edge). Positions are the origin plus these offsets, modulo 2^POS_W.
- R3: With `split` set, the walk adds row K/2, columns 1 to K−1, with mask 2. A walk therefore lasts 2K−1 cycles, or 3K−2 when split. `busy` and `req_valid` are high for exactly those cycles.
- R4: A `start` pulse is accepted only while the engine is idle. A pulse raised while a walk is running has no effect on the requests of that walk.
- R5: Each request cycle gives exactly one result in the next cycle, with the same position and mask.
- R6: If neither `seg_pu` nor `seg_tu` is set, the strength is 0 whatever the block data.
- R7: On a flagged edge (`seg_pu` or `seg_tu` set), an intra flag on P or Q gives strength 2.
- R8: On a transform edge without intra, a non-zero-coefficient flag on P or Q gives 1. On a prediction-only edge, those flags are ignored.
- R9: On a prediction edge, P and Q get strength 1 in two cases: their vector counts differ (`*_two` = 1 means two vectors), or their reference identifiers differ as a set.
- R10: When both blocks have one vector and the same reference, the strength is 1 if the x or y components differ by 4 or more. The vectors are packed as {y, x}, signed, with x in the low half.
- R11: When both blocks have two vectors and P's two references differ, vectors are paired by matching reference. The strength is 1 if either pair is 4 or more apart.
- R12: When all four references are equal, both the straight pairing (0–0, 1–1) and the crossed pairing (0–1, 1–0) are tested. The strength is 1 only if both pairings fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| org_x | input | POS_W | Unit origin column, 4-sample units |
| org_y | input | POS_W | Unit origin row, 4-sample units |
| size_log2 | input | 3 | log2 of unit size, 3 to MAX_LOG2 |
| split | input | 1 | Coding unit holds a second prediction unit |
| busy | output | 1 | Walk in progress |
| req_valid | output | 1 | A segment is requested this cycle |
| req_x | output | POS_W | Requested segment column |
| req_y | output | POS_W | Requested segment row |
| req_mask | output | 2 | bit0 vertical edge, bit1 horizontal edge |
| seg_pu | input | 1 | Segment lies on a prediction-unit edge |
| seg_tu | input | 1 | Segment lies on a transform-unit edge |
| p_intra | input | 1 | P is intra coded |
| q_intra | input | 1 | Q is intra coded |
| p_nz | input | 1 | P has non-zero coefficients |
| q_nz | input | 1 | Q has non-zero coefficients |
| p_two | input | 1 | P carries two vectors |
| q_two | input | 1 | Q carries two vectors |
| p_ref0 | input | REF_W | P reference of vector 0 |
| p_ref1 | input | REF_W | P reference of vector 1 |
| q_ref0 | input | REF_W | Q reference of vector 0 |
| q_ref1 | input | REF_W | Q reference of vector 1 |
| p_mv0 | input | 2*MV_W | P vector 0, {y, x} |
| p_mv1 | input | 2*MV_W | P vector 1, {y, x} |
| q_mv0 | input | 2*MV_W | Q vector 0, {y, x} |
| q_mv1 | input | 2*MV_W | Q vector 1, {y, x} |
| res_valid | output | 1 | Strength result valid |
| res_x | output | POS_W | Result segment column |
| res_y | output | POS_W | Result segment row |
| res_mask | output | 2 | Result edge mask |
| res_bs | output | 2 | Boundary strength 0, 1 or 2 |

## Verification
The case hardest to reach from the ports is two bi-predicted blocks whose four references are all the same picture. Here only one of the two pairings is close, so a design that tests one pairing alone gives the wrong answer. The stimulus builds vectors that are close only when crossed, and others that fail both ways. It also covers bi-predicted blocks with swapped reference order, where pairing by position instead of by reference flips the result. A start pulse raised in the middle of a walk, with a different origin, shows whether the running walk is disturbed.

// File: rtl/dbk_bs_pkg.sv
package dbk_bs_pkg;
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_LEFT  = 2'd1,
      WS_TOP   = 2'd2,
      WS_INNER = 2'd3
   } walk_state_t;

   localparam logic [1:0] MASK_VERT = 2'b01;
   localparam logic [1:0] MASK_HORZ = 2'b10;
   localparam logic [1:0] MASK_BOTH = 2'b11;

   localparam logic [1:0] BS_NONE   = 2'd0;
   localparam logic [1:0] BS_WEAK   = 2'd1;
   localparam logic [1:0] BS_STRONG = 2'd2;
endpackage

// File: rtl/dbk_bs_walker.sv
module dbk_bs_walker
   import dbk_bs_pkg::*;
#(
   parameter int POS_W    = 10,
   parameter int MAX_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [POS_W-1:0] org_x,
   input  logic [POS_W-1:0] org_y,
   input  logic [2:0]       size_log2,
   input  logic             split,
   output logic             busy,
   output logic             req_valid,
   output logic [POS_W-1:0] req_x,
   output logic [POS_W-1:0] req_y,
   output logic [1:0]       req_mask
);
   localparam int CW = MAX_LOG2 - 1;
   localparam logic [2:0] LG_MIN = 3'd3;
   localparam logic [2:0] LG_MAX = 3'(MAX_LOG2);

   walk_state_t      st;
   logic [POS_W-1:0] ox, oy;
   logic [CW-1:0]    kq, idx;
   logic             two_pu;
   logic [2:0]       lg_c;
   logic [CW-1:0]    k_new;
   logic             at_end;

   always_comb begin
      if (size_log2 < LG_MIN)      lg_c = LG_MIN;
      else if (size_log2 > LG_MAX) lg_c = LG_MAX;
      else                         lg_c = size_log2;
      k_new = CW'(1) << (lg_c - 3'd2);
   end

   assign at_end = (idx == kq - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= WS_IDLE;
         ox     <= '0;
         oy     <= '0;
         kq     <= '0;
         idx    <= '0;
         two_pu <= 1'b0;
      end else begin
         case (st)
            WS_IDLE: if (start) begin
               ox     <= org_x;
               oy     <= org_y;
               kq     <= k_new;
               two_pu <= split;
               idx    <= '0;
               st     <= WS_LEFT;
            end
            WS_LEFT: if (at_end) begin
               idx <= CW'(1);
               st  <= WS_TOP;
            end else idx <= idx + CW'(1);
            WS_TOP: if (at_end) begin
               idx <= CW'(1);
               st  <= two_pu ? WS_INNER : WS_IDLE;
            end else idx <= idx + CW'(1);
            default: if (at_end) begin
               idx <= '0;
               st  <= WS_IDLE;
            end else idx <= idx + CW'(1);
         endcase
      end
   end

   always_comb begin
      busy      = (st != WS_IDLE);
      req_valid = busy;
      req_x     = ox;
      req_y     = oy;
      req_mask  = MASK_HORZ;
      case (st)
         WS_LEFT: begin
            req_y    = oy + POS_W'(idx);
            req_mask = (idx == '0) ? MASK_BOTH : MASK_VERT;
         end
         WS_TOP:   req_x = ox + POS_W'(idx);
         WS_INNER: begin
            req_x = ox + POS_W'(idx);
            req_y = oy + POS_W'(kq >> 1);
         end
         default: req_mask = MASK_HORZ;
      endcase
   end

   // R2
   corner_then_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_mask == MASK_BOTH |=> req_valid && req_mask == MASK_VERT);

   // R2
   start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> req_valid && req_mask == MASK_BOTH
                         && req_x == $past(org_x) && req_y == $past(org_y));

   // R4
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !(req_valid && req_mask == MASK_BOTH));
endmodule

// File: rtl/dbk_bs_mvdiff.sv
module dbk_bs_mvdiff #(
   parameter int MV_W = 16,
   parameter int THR  = 4
) (
   input  logic [2*MV_W-1:0] mv_a,
   input  logic [2*MV_W-1:0] mv_b,
   output logic              far
);
   localparam logic [MV_W:0] THR_V = (MV_W+1)'(THR);

   logic signed [MV_W:0] dx, dy;
   logic        [MV_W:0] ax, ay;

   always_comb begin
      dx  = $signed({mv_a[MV_W-1], mv_a[MV_W-1:0]})
          - $signed({mv_b[MV_W-1], mv_b[MV_W-1:0]});
      dy  = $signed({mv_a[2*MV_W-1], mv_a[2*MV_W-1:MV_W]})
          - $signed({mv_b[2*MV_W-1], mv_b[2*MV_W-1:MV_W]});
      ax  = dx[MV_W] ? $unsigned(-dx) : $unsigned(dx);
      ay  = dy[MV_W] ? $unsigned(-dy) : $unsigned(dy);
      far = (ax >= THR_V) || (ay >= THR_V);
   end
endmodule

// File: rtl/dbk_bs_decide.sv
module dbk_bs_decide
   import dbk_bs_pkg::*;
#(
   parameter int MV_W  = 16,
   parameter int REF_W = 4,
   parameter int THR   = 4
) (
   input  logic              seg_pu,
   input  logic              seg_tu,
   input  logic              p_intra,
   input  logic              q_intra,
   input  logic              p_nz,
   input  logic              q_nz,
   input  logic              p_two,
   input  logic              q_two,
   input  logic [REF_W-1:0]  p_ref0,
   input  logic [REF_W-1:0]  p_ref1,
   input  logic [REF_W-1:0]  q_ref0,
   input  logic [REF_W-1:0]  q_ref1,
   input  logic [2*MV_W-1:0] p_mv0,
   input  logic [2*MV_W-1:0] p_mv1,
   input  logic [2*MV_W-1:0] q_mv0,
   input  logic [2*MV_W-1:0] q_mv1,
   output logic [1:0]        bs
);
   localparam int NPAIR = 4;

   // pair order: 0 = P0/Q0, 1 = P1/Q1, 2 = P0/Q1, 3 = P1/Q0
   logic [2*MV_W-1:0] side_a [NPAIR];
   logic [2*MV_W-1:0] side_b [NPAIR];
   logic [NPAIR-1:0]  far;

   assign side_a[0] = p_mv0;  assign side_b[0] = q_mv0;
   assign side_a[1] = p_mv1;  assign side_b[1] = q_mv1;
   assign side_a[2] = p_mv0;  assign side_b[2] = q_mv1;
   assign side_a[3] = p_mv1;  assign side_b[3] = q_mv0;

   for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      dbk_bs_mvdiff #(.MV_W(MV_W), .THR(THR)) diff_i (
         .mv_a (side_a[g]),
         .mv_b (side_b[g]),
         .far  (far[g])
      );
   end

   logic straight_bad, cross_bad, set_same, motion_bad;

   always_comb begin
      straight_bad = far[0] | far[1];
      cross_bad    = far[2] | far[3];
      set_same     = ((p_ref0 == q_ref0) && (p_ref1 == q_ref1))
                  || ((p_ref0 == q_ref1) && (p_ref1 == q_ref0));
      if (p_two != q_two)        motion_bad = 1'b1;
      else if (!p_two)           motion_bad = (p_ref0 != q_ref0) | far[0];
      else if (!set_same)        motion_bad = 1'b1;
      else if (p_ref0 != p_ref1) motion_bad = (p_ref0 == q_ref0) ? straight_bad : cross_bad;
      else                       motion_bad = straight_bad & cross_bad;

      if (!(seg_pu || seg_tu))              bs = BS_NONE;
      else if (p_intra || q_intra)          bs = BS_STRONG;
      else if (seg_tu && (p_nz || q_nz))    bs = BS_WEAK;
      else if (seg_pu && motion_bad)        bs = BS_WEAK;
      else                                  bs = BS_NONE;
   end
endmodule

// File: rtl/dbk_bs_engine.sv
module dbk_bs_engine
   import dbk_bs_pkg::*;
#(
   parameter int POS_W    = 10,
   parameter int MV_W     = 16,
   parameter int REF_W    = 4,
   parameter int MAX_LOG2 = 6,
   parameter int THR      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [POS_W-1:0]  org_x,
   input  logic [POS_W-1:0]  org_y,
   input  logic [2:0]        size_log2,
   input  logic              split,
   output logic              busy,
   output logic              req_valid,
   output logic [POS_W-1:0]  req_x,
   output logic [POS_W-1:0]  req_y,
   output logic [1:0]        req_mask,
   input  logic              seg_pu,
   input  logic              seg_tu,
   input  logic              p_intra,
   input  logic              q_intra,
   input  logic              p_nz,
   input  logic              q_nz,
   input  logic              p_two,
   input  logic              q_two,
   input  logic [REF_W-1:0]  p_ref0,
   input  logic [REF_W-1:0]  p_ref1,
   input  logic [REF_W-1:0]  q_ref0,
   input  logic [REF_W-1:0]  q_ref1,
   input  logic [2*MV_W-1:0] p_mv0,
   input  logic [2*MV_W-1:0] p_mv1,
   input  logic [2*MV_W-1:0] q_mv0,
   input  logic [2*MV_W-1:0] q_mv1,
   output logic              res_valid,
   output logic [POS_W-1:0]  res_x,
   output logic [POS_W-1:0]  res_y,
   output logic [1:0]        res_mask,
   output logic [1:0]        res_bs
);
   if (MAX_LOG2 < 3 || MAX_LOG2 > 7) begin : g_bad_size
      $error("dbk_bs_engine: MAX_LOG2 must lie in 3..7");
   end
   if (POS_W < MAX_LOG2 - 1) begin : g_bad_pos
      $error("dbk_bs_engine: POS_W too narrow for the walk offsets");
   end
   if (THR < 1 || MV_W < 4 || REF_W < 1) begin : g_bad_cmp
      $error("dbk_bs_engine: THR, MV_W or REF_W out of range");
   end

   logic [1:0] bs_now;

   dbk_bs_walker #(.POS_W(POS_W), .MAX_LOG2(MAX_LOG2)) walk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .org_x     (org_x),
      .org_y     (org_y),
      .size_log2 (size_log2),
      .split     (split),
      .busy      (busy),
      .req_valid (req_valid),
      .req_x     (req_x),
      .req_y     (req_y),
      .req_mask  (req_mask)
   );

   dbk_bs_decide #(.MV_W(MV_W), .REF_W(REF_W), .THR(THR)) dec_i (
      .seg_pu  (seg_pu),
      .seg_tu  (seg_tu),
      .p_intra (p_intra),
      .q_intra (q_intra),
      .p_nz    (p_nz),
      .q_nz    (q_nz),
      .p_two   (p_two),
      .q_two   (q_two),
      .p_ref0  (p_ref0),
      .p_ref1  (p_ref1),
      .q_ref0  (q_ref0),
      .q_ref1  (q_ref1),
      .p_mv0   (p_mv0),
      .p_mv1   (p_mv1),
      .q_mv0   (q_mv0),
      .q_mv1   (q_mv1),
      .bs      (bs_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_x     <= '0;
         res_y     <= '0;
         res_mask  <= '0;
         res_bs    <= BS_NONE;
      end else begin
         res_valid <= req_valid;
         res_x     <= req_x;
         res_y     <= req_y;
         res_mask  <= req_mask;
         res_bs    <= req_valid ? bs_now : BS_NONE;
      end
   end

   // R5
   result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid && res_x == $past(req_x) && res_y == $past(req_y)
                    && res_mask == $past(req_mask));

   // R6
   unflagged_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !seg_pu && !seg_tu |=> res_bs == BS_NONE);

   // R7
   intra_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (p_intra || q_intra) && (seg_pu || seg_tu) |=> res_bs == BS_STRONG);

   // R8
   coef_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && seg_tu && (p_nz || q_nz) |=> res_bs != BS_NONE);
endmodule

// File: tb/dbk_bs_engine_tb_top.sv
module dbk_bs_engine_tb_top;
   localparam int POS_W = 10;
   localparam int MV_W  = 16;
   localparam int REF_W = 4;
   localparam int PMASK = (1 << POS_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              start = 1'b0, split = 1'b0;
   logic [POS_W-1:0]  org_x = '0, org_y = '0;
   logic [2:0]        size_log2 = 3'd3;
   logic              busy, req_valid, res_valid;
   logic [POS_W-1:0]  req_x, req_y, res_x, res_y;
   logic [1:0]        req_mask, res_mask, res_bs;
   logic              seg_pu = 0, seg_tu = 0, p_intra = 0, q_intra = 0;
   logic              p_nz = 0, q_nz = 0, p_two = 0, q_two = 0;
   logic [REF_W-1:0]  p_ref0 = '0, p_ref1 = '0, q_ref0 = '0, q_ref1 = '0;
   logic [2*MV_W-1:0] p_mv0 = '0, p_mv1 = '0, q_mv0 = '0, q_mv1 = '0;

   dbk_bs_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
      .size_log2(size_log2), .split(split), .busy(busy), .req_valid(req_valid),
      .req_x(req_x), .req_y(req_y), .req_mask(req_mask), .seg_pu(seg_pu),
      .seg_tu(seg_tu), .p_intra(p_intra), .q_intra(q_intra), .p_nz(p_nz),
      .q_nz(q_nz), .p_two(p_two), .q_two(q_two), .p_ref0(p_ref0), .p_ref1(p_ref1),
      .q_ref0(q_ref0), .q_ref1(q_ref1), .p_mv0(p_mv0), .p_mv1(p_mv1),
      .q_mv0(q_mv0), .q_mv1(q_mv1), .res_valid(res_valid), .res_x(res_x),
      .res_y(res_y), .res_mask(res_mask), .res_bs(res_bs)
   );

   typedef struct { int x; int y; int m; } seg_t;
   typedef struct { int x; int y; int m; int bs; string tag; } res_t;

   seg_t req_q[$];
   res_t res_q[$];
   int   tests = 0, fails = 0, cyc = 0, cc = 0;
   bit   want_start = 0, rogue = 0, after_rogue = 0;
   int   st_x, st_y, st_lg, st_sp;

   // behavioural block data
   int   d_pu, d_tu, d_pi, d_qi, d_pn, d_qn, d_p2, d_q2;
   int   pr[2], qr[2], pmx[2], pmy[2], qmx[2], qmy[2];
   string seg_tag;

   task automatic chk(bit ok, string tag, string what, int got, int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
      end
   endtask

   function automatic bit far_pair(int ax, int ay, int bx, int by);
      int ddx = ax - bx;
      int ddy = ay - by;
      if (ddx < 0) ddx = -ddx;
      if (ddy < 0) ddy = -ddy;
      return (ddx >= 4) || (ddy >= 4);
   endfunction

   function automatic int model_bs();
      bit good;
      if (d_pu == 0 && d_tu == 0) return 0;
      if (d_pi != 0 || d_qi != 0) return 2;
      if (d_tu != 0 && (d_pn != 0 || d_qn != 0)) return 1;
      if (d_pu == 0) return 0;
      if (d_p2 != d_q2) return 1;
      if (d_p2 == 0)
         return (pr[0] != qr[0] || far_pair(pmx[0], pmy[0], qmx[0], qmy[0])) ? 1 : 0;
      good = 0;
      for (int a = 0; a < 2; a++) begin
         if (pr[0] == qr[a] && pr[1] == qr[1-a]
             && !far_pair(pmx[0], pmy[0], qmx[a], qmy[a])
             && !far_pair(pmx[1], pmy[1], qmx[1-a], qmy[1-a]))
            good = 1;
      end
      return good ? 0 : 1;
   endfunction

   function automatic int rmv();
      return int'($urandom % 11) - 5;
   endfunction

   task automatic set_mv(int px0, int py0, int px1, int py1,
                         int qx0, int qy0, int qx1, int qy1);
      pmx[0] = px0; pmy[0] = py0; pmx[1] = px1; pmy[1] = py1;
      qmx[0] = qx0; qmy[0] = qy0; qmx[1] = qx1; qmy[1] = qy1;
   endtask

   task automatic fill_seg();
      d_pu = 1; d_tu = 0; d_pi = 0; d_qi = 0; d_pn = 0; d_qn = 0; d_p2 = 0; d_q2 = 0;
      pr[0] = 1; pr[1] = 1; qr[0] = 1; qr[1] = 1;
      set_mv(0, 0, 0, 0, 0, 0, 0, 0);
      case (cc % 16)
         0:  begin d_pi = 1; seg_tag = "R7"; end
         1:  begin d_pu = 0; d_tu = 1; d_qn = 1; seg_tag = "R8"; end
         2:  begin set_mv(0, 0, 0, 0, 3, -3, 0, 0); seg_tag = "R10"; end
         3:  begin set_mv(0, 0, 0, 0, 4, 0, 0, 0); seg_tag = "R10"; end
         4:  begin d_q2 = 1; seg_tag = "R9"; end
         5:  begin d_p2 = 1; d_q2 = 1; pr[0] = 1; pr[1] = 2; qr[0] = 2; qr[1] = 1;
                   set_mv(0, 0, 10, 10, 10, 11, 1, 0); seg_tag = "R11"; end
         6:  begin d_p2 = 1; d_q2 = 1; pr[0] = 1; pr[1] = 2; qr[0] = 1; qr[1] = 2;
                   set_mv(0, 0, 10, 10, 10, 10, 0, 0); seg_tag = "R11"; end
         7:  begin d_p2 = 1; d_q2 = 1; pr = '{3, 3}; qr = '{3, 3};
                   set_mv(0, 0, 8, 8, 8, 8, 0, 0); seg_tag = "R12"; end
         8:  begin d_p2 = 1; d_q2 = 1; pr = '{3, 3}; qr = '{3, 3};
                   set_mv(0, 0, 8, 8, 0, 5, 8, 8); seg_tag = "R12"; end
         9:  begin d_pu = 0; d_tu = 0; d_pi = 1; d_pn = 1; seg_tag = "R6"; end
         10: begin d_pn = 1; seg_tag = "R8"; end
         11: begin qr[0] = 2; seg_tag = "R9"; end
         12: begin d_p2 = 1; d_q2 = 1; pr[0] = 1; pr[1] = 2; qr[0] = 1; qr[1] = 3;
                   seg_tag = "R9"; end
         default: begin
            d_pu = int'($urandom % 2); d_tu = int'($urandom % 2);
            d_pi = ($urandom % 8 == 0); d_qi = ($urandom % 8 == 0);
            d_pn = int'($urandom % 2); d_qn = int'($urandom % 2);
            d_p2 = int'($urandom % 2); d_q2 = int'($urandom % 2);
            pr[0] = int'($urandom % 3); pr[1] = int'($urandom % 3);
            qr[0] = int'($urandom % 3); qr[1] = int'($urandom % 3);
            set_mv(rmv(), rmv(), rmv(), rmv(), rmv(), rmv(), rmv(), rmv());
            seg_tag = "R9";
         end
      endcase
      cc++;
   endtask

   task automatic drive_seg();
      seg_pu = 1'(d_pu); seg_tu = 1'(d_tu); p_intra = 1'(d_pi); q_intra = 1'(d_qi);
      p_nz = 1'(d_pn); q_nz = 1'(d_qn); p_two = 1'(d_p2); q_two = 1'(d_q2);
      p_ref0 = REF_W'(pr[0]); p_ref1 = REF_W'(pr[1]);
      q_ref0 = REF_W'(qr[0]); q_ref1 = REF_W'(qr[1]);
      p_mv0 = {MV_W'(pmy[0]), MV_W'(pmx[0])}; p_mv1 = {MV_W'(pmy[1]), MV_W'(pmx[1])};
      q_mv0 = {MV_W'(qmy[0]), MV_W'(qmx[0])}; q_mv1 = {MV_W'(qmy[1]), MV_W'(qmx[1])};
   endtask

   task automatic push_walk(int ox, int oy, int lg, int sp);
      int k = 1 << (lg - 2);
      for (int r = 0; r < k; r++) req_q.push_back('{ox & PMASK, (oy + r) & PMASK, (r == 0) ? 3 : 1});
      for (int c = 1; c < k; c++) req_q.push_back('{(ox + c) & PMASK, oy & PMASK, 2});
      if (sp != 0)
         for (int c = 1; c < k; c++)
            req_q.push_back('{(ox + c) & PMASK, (oy + k / 2) & PMASK, 2});
   endtask

   task automatic tick();
      bit popped;
      seg_t s;
      res_t r;
      string ptag;
      @(negedge clk);
      start = 1'b0;
      if (res_q.size() > 0) begin
         r = res_q.pop_front();
         chk(res_valid == 1'b1, "R5", "res_valid", int'(res_valid), 1);
         chk(int'(res_x) == r.x && int'(res_y) == r.y, "R5", "res position x", int'(res_x), r.x);
         chk(int'(res_mask) == r.m, "R5", "res_mask", int'(res_mask), r.m);
         chk(int'(res_bs) == r.bs, r.tag, "res_bs", int'(res_bs), r.bs);
      end else begin
         chk(res_valid == 1'b0, "R3", "idle res_valid", int'(res_valid), 0);
      end
      popped = 0;
      ptag = after_rogue ? "R4" : "R2";
      if (req_q.size() > 0) begin
         s = req_q.pop_front();
         popped = 1;
         chk(req_valid && busy, "R3", "req_valid/busy", int'(req_valid), 1);
         chk(int'(req_x) == s.x, ptag, "req_x", int'(req_x), s.x);
         chk(int'(req_y) == s.y, ptag, "req_y", int'(req_y), s.y);
         chk(int'(req_mask) == s.m, ptag, "req_mask", int'(req_mask), s.m);
         fill_seg();
         drive_seg();
         res_q.push_back('{s.x, s.y, s.m, model_bs(), seg_tag});
      end else begin
         chk(!req_valid && !busy, "R3", "idle req_valid/busy", int'(req_valid), 0);
         after_rogue = 0;
      end
      if (want_start && !popped && req_q.size() == 0) begin
         start = 1'b1; org_x = POS_W'(st_x); org_y = POS_W'(st_y);
         size_log2 = 3'(st_lg); split = 1'(st_sp);
         push_walk(st_x, st_y, st_lg, st_sp);
         want_start = 0;
      end else if (rogue) begin
         start = 1'b1; org_x = POS_W'(st_x + 77); org_y = POS_W'(st_y + 33);
         size_log2 = 3'd3; split = 1'b0;
         rogue = 0; after_rogue = 1;
      end
   endtask

   task automatic do_walk(int ox, int oy, int lg, int sp, int rogue_at);
      int n = 0;
      st_x = ox; st_y = oy; st_lg = lg; st_sp = sp; want_start = 1;
      while (want_start) tick();
      while (req_q.size() > 0 || res_q.size() > 0) begin
         n++;
         if (n == rogue_at) rogue = 1;
         tick();
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, 50000);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
      chk(req_valid == 1'b0, "R1", "req_valid", int'(req_valid), 0);
      chk(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
      rst_n = 1'b1;
      tick();
      chk(busy == 1'b0 && res_valid == 1'b0, "R1", "after release", int'(busy), 0);
      for (int lg = 3; lg <= 6; lg++)
         for (int sp = 0; sp < 2; sp++) begin
            do_walk(8 * lg + sp, 4 * lg, lg, sp, 0);
            do_walk(PMASK - 2, PMASK - 1, lg, sp, 0);   // wrap of positions
         end
      // R4: start raised mid-walk must not disturb the running walk
      do_walk(100, 200, 6, 1, 5);
      do_walk(12, 40, 5, 0, 2);
      // back-to-back walks and longer random traffic
      for (int i = 0; i < 40; i++)
         do_walk(int'($urandom % 1024), int'($urandom % 1024),
                 3 + int'($urandom % 4), int'($urandom % 2), 0);
      repeat (3) tick();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule